// File: doc/BRIEF.md
# E1 Transmit Framer

This block turns parallel data into the serial 2.048 Mbit/s E1 line stream, one bit for each cycle in which the bit enable is high. It walks a fixed position: 8 bits per timeslot, 32 timeslots per frame and 16 frames per multiframe. Around the 30 traffic slots it inserts two overhead structures that nest inside each other. Timeslot 0 alternates between the frame alignment byte in even frames and a byte with the marker bit forced high in odd frames. Timeslot 16 carries the multiframe marker in frame 0 and two channel-associated signalling nibbles in every other frame.

Payload bytes come from an upstream source through a byte request. The framer raises the request in the enabled cycle that sends the first bit of a traffic slot and gives the slot number with it. The source answers in that same cycle, and its byte goes onto the line MSB first. The first bit of each frame is marked by a one-cycle strobe, and a second strobe marks the first bit of each multiframe. Line coding and checksum generation belong to other blocks.

Top module: `e1_tx_framer`

## Requirements
- R1: In reset, `tx_bit`, `frame_start` and `mf_start` are 0. After reset the first enabled bit is bit 1 of timeslot 0 in frame 0, and it is flagged by both strobes.
- R2: Each slot is sent as 8 bits, MSB first. A frame is 32 slots, and consecutive `frame_start` pulses are exactly 256 enabled bits apart.
- R3: In even frames, timeslot 0 is `ts0_b1` followed by the seven bits 0011011.
- R4: In odd frames, timeslot 0 is `ts0_b1`, then a 1, then `odd_spare[5:0]` sent MSB first.
- R5: In frame 0, timeslot 16 is four zeros followed by `mf_spare[3:0]`, MSB first.
- R6: In frame n (1..15), timeslot 16 sends the nibble of timeslot n first and then the nibble of timeslot n+16. The nibble of traffic channel c sits at `sig_bits[4c+3:4c]`. Timeslots 1..15 are channels 0..14 and timeslots 17..31 are channels 15..29.
- R7: `pay_req` is high only in an enabled cycle that sends bit 1 of a traffic slot (never slot 0 or 16), with `pay_slot` set to that slot number. The `pay_data` sampled in that cycle is sent MSB first over the slot.
- R8: `frame_start` is a one-cycle pulse. It follows the clock edge that puts bit 1 of timeslot 0 on `tx_bit`.
- R9: `mf_start` pulses only together with `frame_start` in frame 0, so it comes every 16 frames (4096 enabled bits).
- R10: While `bit_en` is low, `tx_bit` holds, the position does not move, and neither strobe nor `pay_req` is raised.
- R11: The overhead inputs (`ts0_b1`, `odd_spare`, `mf_spare`, `sig_bits`) are sampled at the first bit of slot 0 or slot 16. Changes later in that slot do not alter its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Send one bit in this cycle |
| pay_data | input | 8 | Payload byte returned for the requested slot |
| pay_req | output | 1 | Payload byte request |
| pay_slot | output | 5 | Slot number of the request |
| sig_bits | input | 120 | Signalling nibbles, 4 bits per traffic channel |
| ts0_b1 | input | 1 | First bit of timeslot 0 in every frame |
| odd_spare | input | 6 | Last six bits of timeslot 0 in odd frames |
| mf_spare | input | 4 | Last four bits of timeslot 16 in frame 0 |
| tx_bit | output | 1 | Serial line bit |
| frame_start | output | 1 | First bit of frame strobe |
| mf_start | output | 1 | First bit of multiframe strobe |

## Verification
A slip in the bit, slot or frame counter shows within one frame as a `frame_start` spacing other than 256 enabled bits, and within at most 8 bits as overhead or payload bits out of place. A frame counter that is off by one or mis-decoded sends the wrong timeslot 0 pattern at the next frame. A wrong signalling index sends the wrong nibble within a single 4096-bit multiframe. The bench models the line bit by bit and checks every enabled and idle cycle, so each such fault is seen at the first affected bit.

// File: rtl/e1fr_pkg.sv
package e1fr_pkg;

    localparam int BITS_PER_SLOT   = 8;
    localparam int SLOTS_PER_FRAME = 32;
    localparam int FRAMES_PER_MF   = 16;
    localparam int NIBBLE          = 4;
    localparam int ALIGN_TS        = 0;
    localparam int SIG_TS          = 16;

    localparam int TRAFFIC_CH  = SLOTS_PER_FRAME - 2;
    localparam int BIT_W       = $clog2(BITS_PER_SLOT);
    localparam int SLOT_W      = $clog2(SLOTS_PER_FRAME);
    localparam int FRAME_W     = $clog2(FRAMES_PER_MF);
    localparam int SIG_W       = TRAFFIC_CH * NIBBLE;
    localparam int ODD_SPARE_W = BITS_PER_SLOT - 2;
    localparam int MF_SPARE_W  = BITS_PER_SLOT - NIBBLE;

    localparam logic [BITS_PER_SLOT-2:0] ALIGN_WORD = 7'b0011011;

    typedef logic [BITS_PER_SLOT-1:0] octet_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SLOT_W-1:0]  slot;
        logic [BIT_W-1:0]   bitn;
    } tdm_pos_t;

    typedef enum logic [1:0] {
        KIND_ALIGN,
        KIND_SIG,
        KIND_TRAFFIC
    } slot_kind_e;

    function automatic slot_kind_e classify(input logic [SLOT_W-1:0] s);
        if (s == SLOT_W'(ALIGN_TS))
            return KIND_ALIGN;
        else if (s == SLOT_W'(SIG_TS))
            return KIND_SIG;
        else
            return KIND_TRAFFIC;
    endfunction

    function automatic octet_t align_octet(input logic odd_frame,
                                           input logic b1,
                                           input logic [ODD_SPARE_W-1:0] spare);
        if (odd_frame)
            return {b1, 1'b1, spare};
        else
            return {b1, ALIGN_WORD};
    endfunction

endpackage

// File: rtl/e1fr_position.sv
module e1fr_position
    import e1fr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    output tdm_pos_t pos,
    output logic     slot_first
);
    localparam logic [BIT_W-1:0]   LAST_BIT   = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(SLOTS_PER_FRAME - 1);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES_PER_MF - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            if (pos.bitn == LAST_BIT) begin
                pos.bitn <= '0;
                if (pos.slot == LAST_SLOT) begin
                    pos.slot  <= '0;
                    pos.frame <= (pos.frame == LAST_FRAME) ? '0 : pos.frame + 1'b1;
                end else begin
                    pos.slot <= pos.slot + 1'b1;
                end
            end else begin
                pos.bitn <= pos.bitn + 1'b1;
            end
        end
    end

    assign slot_first = (pos.bitn == '0);

    // R2: after the last bit of a slot the slot number moves on by one
    a_r2_slot_advance: assert property (@(posedge clk) disable iff (rst)
        (step && pos.bitn == LAST_BIT) |=> (pos.slot == $past(pos.slot) + 1'b1));

    // R10: no movement without an enable
    a_r10_pos_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos));

endmodule

// File: rtl/e1fr_overhead.sv
module e1fr_overhead
    import e1fr_pkg::*;
(
    input  logic [FRAME_W-1:0]     frame,
    input  logic                   ts0_b1,
    input  logic [ODD_SPARE_W-1:0] odd_spare,
    input  logic [MF_SPARE_W-1:0]  mf_spare,
    input  logic [SIG_W-1:0]       sig_bits,
    output octet_t                 align_byte,
    output octet_t                 sig_byte
);
    octet_t sig_tbl [FRAMES_PER_MF];

    assign sig_tbl[0] = {{NIBBLE{1'b0}}, mf_spare};

    // frame n: slot n first (channel n-1), then slot n+16 (channel n+14)
    for (genvar n = 1; n < FRAMES_PER_MF; n++) begin : g_sig
        assign sig_tbl[n] = {sig_bits[NIBBLE*(n-1) +: NIBBLE],
                             sig_bits[NIBBLE*(n+SIG_TS-2) +: NIBBLE]};
    end

    assign align_byte = align_octet(frame[0], ts0_b1, odd_spare);
    assign sig_byte   = sig_tbl[frame];

endmodule

// File: rtl/e1fr_serializer.sv
module e1fr_serializer
    import e1fr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   load,
    input  octet_t load_byte,
    output logic   tx_bit
);
    logic [BITS_PER_SLOT-2:0] rest;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit <= 1'b0;
            rest   <= '0;
        end else if (step) begin
            if (load)
                {tx_bit, rest} <= load_byte;
            else
                {tx_bit, rest} <= {rest, 1'b0};
        end
    end

    // R10: the line bit holds while the enable is low
    a_r10_bit_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(tx_bit));

endmodule

// File: rtl/e1_tx_framer.sv
module e1_tx_framer
    import e1fr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_en,
    input  logic [7:0]             pay_data,
    output logic                   pay_req,
    output logic [4:0]             pay_slot,
    input  logic [119:0]           sig_bits,
    input  logic                   ts0_b1,
    input  logic [5:0]             odd_spare,
    input  logic [3:0]             mf_spare,
    output logic                   tx_bit,
    output logic                   frame_start,
    output logic                   mf_start
);
    tdm_pos_t   pos;
    logic       slot_first;
    slot_kind_e kind;
    octet_t     align_byte;
    octet_t     sig_byte;
    octet_t     next_byte;

    e1fr_position u_pos (
        .clk        (clk),
        .rst        (rst),
        .step       (bit_en),
        .pos        (pos),
        .slot_first (slot_first)
    );

    e1fr_overhead u_oh (
        .frame      (pos.frame),
        .ts0_b1     (ts0_b1),
        .odd_spare  (odd_spare),
        .mf_spare   (mf_spare),
        .sig_bits   (sig_bits),
        .align_byte (align_byte),
        .sig_byte   (sig_byte)
    );

    assign kind     = classify(pos.slot);
    assign pay_req  = bit_en && slot_first && (kind == KIND_TRAFFIC);
    assign pay_slot = pos.slot;

    always_comb begin
        unique case (kind)
            KIND_ALIGN: next_byte = align_byte;
            KIND_SIG:   next_byte = sig_byte;
            default:    next_byte = pay_data;
        endcase
    end

    e1fr_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .step      (bit_en),
        .load      (slot_first),
        .load_byte (next_byte),
        .tx_bit    (tx_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            mf_start    <= 1'b0;
        end else begin
            frame_start <= bit_en && slot_first && (kind == KIND_ALIGN);
            mf_start    <= bit_en && slot_first && (kind == KIND_ALIGN) && (pos.frame == '0);
        end
    end

    // R7: no request in the alignment or signalling slot
    a_r7_req_traffic_only: assert property (@(posedge clk) disable iff (rst)
        pay_req |-> (pay_slot != 5'd0 && pay_slot != 5'd16));

    // R9: multiframe strobe only together with frame strobe
    a_r9_mf_with_frame: assert property (@(posedge clk) disable iff (rst)
        mf_start |-> frame_start);

    // R8: frame strobe lasts a single cycle
    a_r8_fs_one_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R10: no request without an enable
    a_r10_no_req_idle: assert property (@(posedge clk) disable iff (rst)
        !bit_en |-> !pay_req);

endmodule

// File: tb/e1_tx_framer_test.sv
module e1_tx_framer_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         bit_en;
    logic [7:0]   pay_data;
    logic         pay_req;
    logic [4:0]   pay_slot;
    logic [119:0] sig_bits;
    logic         ts0_b1;
    logic [5:0]   odd_spare;
    logic [3:0]   mf_spare;
    logic         tx_bit;
    logic         frame_start;
    logic         mf_start;
    logic [7:0]   pay_seed;

    always #2 clk = ~clk;

    assign pay_data = pay_seed ^ {pay_slot, 3'b101};

    e1_tx_framer uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pay_data(pay_data),
        .pay_req(pay_req), .pay_slot(pay_slot), .sig_bits(sig_bits),
        .ts0_b1(ts0_b1), .odd_spare(odd_spare), .mf_spare(mf_spare),
        .tx_bit(tx_bit), .frame_start(frame_start), .mf_start(mf_start)
    );

    typedef struct packed {
        logic       b1;
        logic [5:0] odd;
        logic [3:0] mfsp;
        logic [7:0] pseed;
        logic [7:0] sseed;
        logic       gaps;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{1'b1, 6'b101010, 4'b1100, 8'h3C, 8'h17, 1'b0},
        '{1'b0, 6'b010101, 4'b0011, 8'hA5, 8'h9E, 1'b1},
        '{1'b1, 6'b111111, 4'b1111, 8'h00, 8'h42, 1'b0},
        '{1'b0, 6'b000000, 4'b0110, 8'hFF, 8'hD1, 1'b1}
    };

    int    n_chk = 0;
    int    n_bad = 0;
    int    bf, bs, bb;
    int    en_cnt, last_fs, last_mf;
    bit    have_fs, have_mf, done;
    logic [7:0] cur_byte;
    logic  exp_tx;
    string tag_ovr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (f%0d ts%0d b%0d)", tag, act, exp, bf, bs, bb);
        end
    endtask

    task automatic load_sig(input logic [7:0] seed);
        for (int c = 0; c < 30; c++)
            sig_bits[4*c +: 4] = seed[3:0] + 4'(c * 5) ^ seed[7:4];
    endtask

    function automatic logic [7:0] exp_byte(input int f, input int s);
        if (s == 0)
            return (f % 2 == 0) ? {ts0_b1, 7'b0011011} : {ts0_b1, 1'b1, odd_spare};
        else if (s == 16)
            return (f == 0) ? {4'b0000, mf_spare}
                            : {sig_bits[4*(f-1) +: 4], sig_bits[4*(f+14) +: 4]};
        else
            return pay_seed ^ {5'(s), 3'b101};
    endfunction

    function automatic string bit_tag(input int f, input int s);
        if (tag_ovr != "") return tag_ovr;
        if (s == 0)  return (f % 2 == 0) ? "R3" : "R4";
        if (s == 16) return (f == 0) ? "R5" : "R6";
        return "R7";
    endfunction

    task automatic model_reset;
        bf = 0; bs = 0; bb = 0;
        exp_tx = 1'b0; have_fs = 0; have_mf = 0; en_cnt = 0;
    endtask

    task automatic step(input logic en);
        logic exp_req, exp_fs, exp_mf;
        bit_en = en;
        #1;
        if (en && bb == 0) cur_byte = exp_byte(bf, bs);
        exp_req = en && bb == 0 && bs != 0 && bs != 16;
        chk(pay_req == exp_req, en ? "R7" : "R10", pay_req, exp_req);
        if (exp_req) chk(pay_slot == 5'(bs), "R7", pay_slot, bs);
        if (en) exp_tx = cur_byte[7 - bb];
        exp_fs = en && bs == 0 && bb == 0;
        exp_mf = exp_fs && bf == 0;
        @(negedge clk);
        chk(tx_bit == exp_tx, en ? bit_tag(bf, bs) : "R10", tx_bit, exp_tx);
        chk(frame_start == exp_fs, en ? "R8" : "R10", frame_start, exp_fs);
        chk(mf_start == exp_mf, "R9", mf_start, exp_mf);
        if (en) begin
            if (frame_start) begin
                if (have_fs) chk(en_cnt - last_fs == 256, "R2", en_cnt - last_fs, 256);
                have_fs = 1; last_fs = en_cnt;
            end
            if (mf_start) begin
                if (have_mf) chk(en_cnt - last_mf == 4096, "R9", en_cnt - last_mf, 4096);
                have_mf = 1; last_mf = en_cnt;
            end
            en_cnt++;
            bb++;
            if (bb == 8) begin
                bb = 0; bs++;
                if (bs == 32) begin
                    bs = 0; bf = (bf + 1) % 16;
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        done = 0; tag_ovr = "";
        rst = 1'b1; bit_en = 1'b1; pay_seed = 8'h00;
        ts0_b1 = 1'b0; odd_spare = '0; mf_spare = '0; sig_bits = '0;
        repeat (3) @(negedge clk);
        chk(tx_bit == 1'b0, "R1", tx_bit, 0);
        chk(frame_start == 1'b0, "R1", frame_start, 0);
        chk(mf_start == 1'b0, "R1", mf_start, 0);
        bit_en = 1'b0;
        rst = 1'b0;
        model_reset();

        // table of line configurations, each run for one multiframe
        foreach (VEC[i]) begin
            ts0_b1 = VEC[i].b1; odd_spare = VEC[i].odd; mf_spare = VEC[i].mfsp;
            pay_seed = VEC[i].pseed; load_sig(VEC[i].sseed);
            for (int k = 0; k < 4096; k++) begin
                if (VEC[i].gaps && (k % 5 == 3)) step(1'b0);
                step(1'b1);
            end
        end

        // R11: overhead inputs change in the middle of each overhead slot
        tag_ovr = "R11";
        for (int k = 0; k < 4096; k++) begin
            if (bb == 3 && (bs == 0 || bs == 16)) begin
                ts0_b1 = ~ts0_b1; odd_spare = ~odd_spare;
                mf_spare = ~mf_spare; sig_bits = ~sig_bits;
            end
            step(1'b1);
        end
        tag_ovr = "";

        // R1: reset in the middle of a frame restarts at frame 0 slot 0
        repeat (77) step(1'b1);
        rst = 1'b1; bit_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_bit == 1'b0, "R1", tx_bit, 0);
        chk(frame_start == 1'b0, "R1", frame_start, 0);
        rst = 1'b0;
        model_reset();
        tag_ovr = "R1";
        step(1'b1);
        tag_ovr = "";
        chk(mf_start == 1'b1, "R1", mf_start, 1);
        for (int k = 0; k < 600; k++) step((k % 3) != 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule